// File: doc/BRIEF.md
# Dual-Side Integration Conversion Sequencer

This block is the control sequencer for a converter that has two integrators, side A and side B. A user-driven CONV line decides when the sides swap. Each edge of CONV, rising or falling, ends the integration on one side and starts it on the other. The side that just stopped integrating then runs a measure/reset/auto-zero window. The sequencer keeps a numbered state, a busy flag for that window, a flag naming the side that is integrating, and an active-low data-ready flag. Data-ready also reports which side's result is waiting. The reader acknowledges a result by taking DCLK high and then back low.

After reset the block always takes a non-continuous start-up path. It waits in state 8 until the first CONV edge. It then runs a long window in state 7, which yields side A and then side B. After that it ping-pongs between state 5 (A integrating, B measured) and state 4 (B integrating, A measured). A CONV edge that arrives while a continuous window is still running drops the sequencer back onto the non-continuous path.

All intervals are counted in clock periods. When `clk4x` is high, an internal divide-by-four enable stretches every interval by four. CONV and DCLK are asynchronous to the clock and each passes through a two-stage synchronizer. Every output is a register.

Top module: `dual_side_sequencer`

## Requirements
- R1: After reset: `stateNum` is 8, `mBusy` is 0, `dvalidN` is 1 and `sideSel` is 0. In state 8 the block stays idle until a CONV edge arrives.
- R2: A CONV edge in state 8 moves the block to state 7, with `mBusy` high and `sideSel` = 1. The side encoding throughout is 0 = side A and 1 = side B.
- R3: In state 7, `mBusy` stays high for exactly 2901 clock periods. `dvalidN` falls 1379 periods after the state change with `dataSide` = 0. It falls again 2829 periods after the state change with `dataSide` = 1. CONV edges that arrive while state 7 is busy are ignored.
- R4: Once a window has finished, a CONV edge moves state 7 or state 4 to state 5 (`sideSel` = 0), and moves state 5 to state 4 (`sideSel` = 1).
- R5: In states 5 and 4, `mBusy` stays high for exactly 1470 clock periods after the state change. `dvalidN` falls 1380 periods after the state change. The data side it reports is 1 in state 5 and 0 in state 4.
- R6: A CONV edge that arrives while state 5 or 4 is still busy moves the block to state 7 and restarts the non-continuous window.
- R7: With `clk4x` = 1, every interval in R3 and R5 is exactly four times longer.
- R8: Once `dvalidN` is low, it returns high on the third rising clock edge after DCLK falls, provided DCLK was seen high while `dvalidN` was low. DCLK held high on its own leaves `dvalidN` low.
- R9: If a new data-ready event falls on the same clock edge as a DCLK release, `dvalidN` stays low and `dataSide` takes the new side.
- R10: The state outputs change on the third rising clock edge after CONV changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rstN | input | 1 | Asynchronous active-low reset |
| conv | input | 1 | User conversion control; every edge swaps the sides |
| dclk | input | 1 | Read clock; a high-then-low pulse acknowledges data |
| clk4x | input | 1 | 1 = stretch every interval by four |
| stateNum | output | 4 | Current state number (8, 7, 5 or 4) |
| mBusy | output | 1 | High while a measure/reset/auto-zero window runs |
| sideSel | output | 1 | Integrating side, 0 = A, 1 = B |
| dataSide | output | 1 | Side whose result is ready, 0 = A, 1 = B |
| dvalidN | output | 1 | Active-low data ready |

## Verification
The data-ready timer and the DCLK acknowledge path can act on the same clock edge. In that case one tries to set `dvalidN` and the other tries to clear it. The bench provokes this collision deliberately. It leaves a result unread, raises DCLK, triggers a continuous window, and then releases DCLK so that the synchronized falling edge lands exactly on the edge where the timer reaches 1380. The bench passes the design only if `dvalidN` stays low at that edge and `dataSide` has switched to the new window's side, and only if a later, separate DCLK pulse clears the result on the third edge.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [3:0] {
    ST_BOOT   = 4'd8,
    ST_NCMEAS = 4'd7,
    ST_INT_A  = 4'd5,
    ST_INT_B  = 4'd4
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic start;   // restart divider and window timer
    logic run;     // window in progress
    logic ncMode;  // non-continuous window targets
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic convEdge;
    logic dclkRise;
    logic dclkFall;
    logic hitFirst;
    logic hitSecond;
    logic windowEnd;
  } dpFlags_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MRAZ_CYC    = 1470,
  parameter int DRDY_CYC    = 1380,
  parameter int NC_DRDY1    = 1379,
  parameter int NC_DRDY2    = 1450,
  parameter int NC_CYC      = 2901
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        conv,
  input  logic        dclk,
  input  logic        clk4x,
  input  ctrlStrobe_t strb,
  output dpFlags_t    flg
);

  localparam int NC_DRDY_B = NC_DRDY1 + NC_DRDY2;
  localparam int MAX_CYC   = (NC_CYC > MRAZ_CYC) ? NC_CYC : MRAZ_CYC;
  localparam int TW        = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] CONT_FIRST = TW'(DRDY_CYC - 1);
  localparam logic [TW-1:0] NC_FIRST   = TW'(NC_DRDY1 - 1);
  localparam logic [TW-1:0] NC_SECOND  = TW'(NC_DRDY_B - 1);
  localparam logic [TW-1:0] CONT_END   = TW'(MRAZ_CYC - 1);
  localparam logic [TW-1:0] NC_END     = TW'(NC_CYC - 1);

  // two synchronizer chains built from one template
  logic [1:0] rawIn;
  logic [1:0] syncOut;
  logic [1:0] syncPrev;
  assign rawIn = {dclk, conv};

  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] shReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        shReg       <= '0;
        syncPrev[g] <= 1'b0;
      end else begin
        shReg       <= {shReg[SYNC_STAGES-2:0], rawIn[g]};
        syncPrev[g] <= shReg[SYNC_STAGES-1];
      end
    end
    assign syncOut[g] = shReg[SYNC_STAGES-1];
  end

  // divide-by-four enable, phase restarted with each window
  logic [1:0]    divCnt;
  logic          tick;
  logic [TW-1:0] timer;

  assign tick = !clk4x || (divCnt == 2'd3);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      timer  <= '0;
    end else if (strb.start) begin
      divCnt <= '0;
      timer  <= '0;
    end else begin
      divCnt <= divCnt + 2'd1;
      if (strb.run && tick) timer <= timer + 1'b1;
    end
  end

  logic [TW-1:0] firstTgt;
  logic [TW-1:0] endTgt;
  assign firstTgt = strb.ncMode ? NC_FIRST : CONT_FIRST;
  assign endTgt   = strb.ncMode ? NC_END   : CONT_END;

  always_comb begin
    flg.convEdge  = syncOut[0] ^ syncPrev[0];
    flg.dclkRise  = syncOut[1] & ~syncPrev[1];
    flg.dclkFall  = ~syncOut[1] & syncPrev[1];
    flg.hitFirst  = strb.run && tick && (timer == firstTgt);
    flg.hitSecond = strb.run && tick && strb.ncMode && (timer == NC_SECOND);
    flg.windowEnd = strb.run && tick && (timer == endTgt);
  end

  // R7: with the divider on, enables never come on consecutive cycles
  a_r7_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
    (clk4x && $past(clk4x) && tick) |-> !$past(tick));

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpFlags_t    flg,
  output ctrlStrobe_t strb,
  output logic [3:0]  stateNum,
  output logic        mBusy,
  output logic        sideSel,
  output logic        dataSide,
  output logic        dvalidN
);

  seqState_t stateQ;
  seqState_t nextSt;
  logic      busyQ;
  logic      sideQ;
  logic      dvalidQ;
  logic      dataSideQ;
  logic      seenHighQ;
  logic      startNc;
  logic      startCont;
  logic      drdyHit;
  logic      drdySide;
  logic      inCont;

  assign inCont = (stateQ == ST_INT_A) || (stateQ == ST_INT_B);

  always_comb begin
    startNc   = flg.convEdge && ((stateQ == ST_BOOT) || (inCont && busyQ));
    startCont = flg.convEdge && !busyQ && (stateQ != ST_BOOT);
    nextSt    = stateQ;
    if (startNc)        nextSt = ST_NCMEAS;
    else if (startCont) nextSt = (stateQ == ST_INT_A) ? ST_INT_B : ST_INT_A;
  end

  always_comb begin
    strb.start  = startNc || startCont;
    strb.run    = busyQ;
    strb.ncMode = (stateQ == ST_NCMEAS);
  end

  assign drdyHit  = flg.hitFirst || flg.hitSecond;
  assign drdySide = (stateQ == ST_NCMEAS) ? flg.hitSecond : (stateQ == ST_INT_A);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_BOOT;
      sideQ  <= 1'b0;
      busyQ  <= 1'b0;
    end else begin
      stateQ <= nextSt;
      sideQ  <= (nextSt == ST_NCMEAS) || (nextSt == ST_INT_B);
      if (strb.start)         busyQ <= 1'b1;
      else if (flg.windowEnd) busyQ <= 1'b0;
    end
  end

  // data-ready handshake: a new result outranks an acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dvalidQ   <= 1'b1;
      dataSideQ <= 1'b0;
      seenHighQ <= 1'b0;
    end else if (drdyHit) begin
      dvalidQ   <= 1'b0;
      dataSideQ <= drdySide;
      seenHighQ <= 1'b0;
    end else if (!dvalidQ) begin
      if (flg.dclkRise) seenHighQ <= 1'b1;
      if (flg.dclkFall && seenHighQ) begin
        dvalidQ   <= 1'b1;
        seenHighQ <= 1'b0;
      end
    end
  end

  assign stateNum = stateQ;
  assign mBusy    = busyQ;
  assign sideSel  = sideQ;
  assign dataSide = dataSideQ;
  assign dvalidN  = dvalidQ;

  a_r1_boot_idle: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_BOOT) |-> (!busyQ && dvalidQ));

  a_r6_early_edge: assert property (@(posedge clk) disable iff (!rstN)
    (flg.convEdge && busyQ && inCont) |=> (stateQ == ST_NCMEAS && busyQ));

  a_r3_nc_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (flg.convEdge && busyQ && stateQ == ST_NCMEAS) |=> (stateQ == ST_NCMEAS));

  a_r8_clear_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dvalidQ) |-> $past(flg.dclkFall));

  a_r9_ready_wins: assert property (@(posedge clk) disable iff (!rstN)
    (flg.hitFirst || flg.hitSecond) |=> !dvalidQ);

endmodule

// File: rtl/dual_side_sequencer.sv
module dual_side_sequencer
  import seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MRAZ_CYC    = 1470,
  parameter int DRDY_CYC    = 1380,
  parameter int NC_DRDY1    = 1379,
  parameter int NC_DRDY2    = 1450,
  parameter int NC_CYC      = 2901
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       conv,
  input  logic       dclk,
  input  logic       clk4x,
  output logic [3:0] stateNum,
  output logic       mBusy,
  output logic       sideSel,
  output logic       dataSide,
  output logic       dvalidN
);

  ctrlStrobe_t strb;
  dpFlags_t    flg;

  seq_datapath #(
    .SYNC_STAGES(SYNC_STAGES), .MRAZ_CYC(MRAZ_CYC), .DRDY_CYC(DRDY_CYC),
    .NC_DRDY1(NC_DRDY1), .NC_DRDY2(NC_DRDY2), .NC_CYC(NC_CYC)
  ) dp_i (
    .clk(clk), .rstN(rstN), .conv(conv), .dclk(dclk), .clk4x(clk4x),
    .strb(strb), .flg(flg)
  );

  seq_control ctl_i (
    .clk(clk), .rstN(rstN), .flg(flg), .strb(strb),
    .stateNum(stateNum), .mBusy(mBusy), .sideSel(sideSel),
    .dataSide(dataSide), .dvalidN(dvalidN)
  );

endmodule

// File: tb/dual_side_sequencer_tb_top.sv
module dual_side_sequencer_tb_top;

  localparam int MR  = 1470;
  localparam int DR  = 1380;
  localparam int NC1 = 1379;
  localparam int NC2 = 2829;
  localparam int NCW = 2901;

  typedef struct packed {
    logic      x4;
    logic [3:0] st;
    logic      intSide;
    int        nFalls;
    int        fall1;
    logic      side1;
    int        fall2;
    logic      side2;
    int        busyLen;
  } row_t;

  localparam row_t ROWS [6] = '{
    '{1'b0, 4'd7, 1'b1, 2, NC1,   1'b0, NC2, 1'b1, NCW},
    '{1'b0, 4'd5, 1'b0, 1, DR,    1'b1, 0,   1'b0, MR},
    '{1'b0, 4'd4, 1'b1, 1, DR,    1'b0, 0,   1'b0, MR},
    '{1'b1, 4'd5, 1'b0, 1, 4*DR,  1'b1, 0,   1'b0, 4*MR},
    '{1'b1, 4'd4, 1'b1, 1, 4*DR,  1'b0, 0,   1'b0, 4*MR},
    '{1'b0, 4'd5, 1'b0, 1, DR,    1'b1, 0,   1'b0, MR}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic conv = 1'b0;
  logic dclk = 1'b0;
  logic clk4x = 1'b0;
  logic [3:0] stateNum;
  logic mBusy, sideSel, dataSide, dvalidN;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_side_sequencer dut_i (
    .clk(clk), .rstN(rstN), .conv(conv), .dclk(dclk), .clk4x(clk4x),
    .stateNum(stateNum), .mBusy(mBusy), .sideSel(sideSel),
    .dataSide(dataSide), .dvalidN(dvalidN)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // toggles CONV and returns the negedges until the state output moves
  task automatic toggleAndWait(output int lat);
    logic [3:0] prev;
    prev = stateNum;
    conv = ~conv;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (stateNum == prev && lat < 20);
  endtask

  task automatic waitIdle();
    int n;
    n = 0;
    while (mBusy && n < 30000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int lat, cnt, nf, hold, f1, f2;
    logic s1, s2;
    bit pulsing;

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(stateNum == 4'd8, "R1", "reset state", stateNum, 8);
    chk(!mBusy && dvalidN && !sideSel, "R1", "reset flags",
        {mBusy, dvalidN, sideSel}, 3'b010);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    chk(stateNum == 4'd8 && !mBusy, "R1", "idle without CONV", stateNum, 8);

    // R2 R3 R4 R5 R7 R10: table walk
    for (int r = 0; r < 6; r++) begin
      clk4x = ROWS[r].x4;
      toggleAndWait(lat);
      chk(lat == 3, "R10", "CONV to state latency", lat, 3);
      chk(stateNum == ROWS[r].st, "R2/R4", "state after edge", stateNum, ROWS[r].st);
      chk(sideSel == ROWS[r].intSide, "R4", "integrating side", sideSel, ROWS[r].intSide);
      chk(mBusy == 1'b1, "R5", "busy at window start", mBusy, 1);
      cnt = 0; nf = 0; hold = 0; pulsing = 0; f1 = 0; f2 = 0; s1 = 0; s2 = 0;
      while (mBusy && cnt < 30000) begin
        @(negedge clk);
        cnt++;
        if (!dvalidN && !pulsing) begin
          if (nf == 0) begin f1 = cnt; s1 = dataSide; end
          else begin f2 = cnt; s2 = dataSide; end
          nf++;
          dclk = 1'b1;
          pulsing = 1;
          hold = 2;
        end else if (pulsing) begin
          if (hold > 0) begin
            hold--;
            if (hold == 0) dclk = 1'b0;
          end else if (dvalidN) pulsing = 0;
        end
      end
      dclk = 1'b0;
      repeat (5) @(negedge clk);
      chk(cnt == ROWS[r].busyLen, "R3/R5/R7", "busy length", cnt, ROWS[r].busyLen);
      chk(nf == ROWS[r].nFalls, "R3/R5", "data-ready count", nf, ROWS[r].nFalls);
      chk(f1 == ROWS[r].fall1, "R3/R5/R7", "first data-ready time", f1, ROWS[r].fall1);
      chk(s1 == ROWS[r].side1, "R3/R5", "first data side", s1, ROWS[r].side1);
      if (ROWS[r].nFalls > 1) begin
        chk(f2 == ROWS[r].fall2, "R3", "second data-ready time", f2, ROWS[r].fall2);
        chk(s2 == ROWS[r].side2, "R3", "second data side", s2, ROWS[r].side2);
      end
      chk(dvalidN == 1'b1, "R8", "pulse cleared data-ready", dvalidN, 1);
    end
    clk4x = 1'b0;

    // R6: early edge in continuous mode
    toggleAndWait(lat);
    chk(stateNum == 4'd4, "R4", "state 5 to 4", stateNum, 4);
    repeat (100) @(negedge clk);
    toggleAndWait(lat);
    chk(stateNum == 4'd7 && mBusy, "R6", "early edge to state 7", stateNum, 7);

    // R3: edge ignored while state 7 busy
    repeat (50) @(negedge clk);
    conv = ~conv;
    repeat (10) @(negedge clk);
    chk(stateNum == 4'd7, "R3", "edge ignored in busy state 7", stateNum, 7);
    waitIdle();
    chk(!dvalidN && dataSide, "R3", "unread side B after state 7",
        {dvalidN, dataSide}, 2'b01);

    // R8: DCLK held high alone leaves data-ready low
    toggleAndWait(lat);
    chk(stateNum == 4'd5, "R4", "state 7 to 5", stateNum, 5);
    waitIdle();
    dclk = 1'b1;
    repeat (20) @(negedge clk);
    chk(dvalidN == 1'b0, "R8", "DCLK high does not clear", dvalidN, 0);

    // R9: release lands on the data-ready edge of state 4
    toggleAndWait(lat);
    chk(stateNum == 4'd4, "R4", "state 5 to 4 again", stateNum, 4);
    repeat (DR - 3) @(negedge clk);
    chk(dvalidN == 1'b0 && dataSide, "R9", "old result still held",
        {dvalidN, dataSide}, 2'b01);
    dclk = 1'b0;
    repeat (3) @(negedge clk);
    chk(dvalidN == 1'b0, "R9", "ready wins over release", dvalidN, 0);
    chk(dataSide == 1'b0, "R9", "side updated to A", dataSide, 0);
    repeat (5) @(negedge clk);
    chk(dvalidN == 1'b0, "R9", "still low after collision", dvalidN, 0);

    // R8: clear timing on the third edge
    dclk = 1'b1;
    repeat (5) @(negedge clk);
    dclk = 1'b0;
    repeat (2) @(negedge clk);
    chk(dvalidN == 1'b0, "R8", "low two edges after release", dvalidN, 0);
    @(negedge clk);
    chk(dvalidN == 1'b1, "R8", "high on third edge", dvalidN, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule